// File: doc/BRIEF.md
# Half-Bridge Gate Fault Guard

This block sits between the two PWM commands of one half-bridge leg and the enables of its high-side and low-side gate stages. Each gate output has a base enable and a boost enable. The boost enable stays on for a fixed number of cycles after each turn-on edge, which gives a strong first push on the gate. Comparator results for desaturation and undervoltage arrive as digital flags. The block turns them into protective actions on the gates.

The leg takes part in two shared open-drain nets. Each net is modelled as a pull-low enable out of the block and a sampled line level into it.

- **Sync-fault net:** a desaturation pulls this net low for as long as the timed soft turn-off runs. Every guard on the net that reads it low freezes its gates.
- **Shutdown net:** while this net reads low, both gates turn off hard. The guard pulls it low while undervoltage persists. It also pulls it low, and keeps it low, once a soft turn-off has finished. A clear input releases that latched pull. While the clear input is held, a desaturation still runs the soft turn-off, but the shutdown pull is not latched afterwards.

Every asynchronous input passes through two flops before it is used. A gate output therefore reacts on the third rising edge after its input changes.

Top module: `hbGateGuard`

## Requirements
- R1: While reset is asserted, every output is low: both gate enables, both boost enables, the soft-turn-off flag, and both net pulls.
- R2: Each input is sampled through a two-flop synchroniser. A gate enable follows its PWM input on the third rising edge after the input changes.
- R3: When both PWM inputs read high, both gate enables go low. The two gate enables are never high together.
- R4: A boost enable is high during the first BOOST_CYCLES cycles that its gate enable is high, and is low otherwise.
- R5: A desaturation flag is ignored during the first BLANK_CYCLES cycles that its gate enable is high. It is also ignored while that gate is off.
- R6: A desaturation seen on a gate that is on starts a soft turn-off. For exactly SSD_CYCLES cycles, the soft-turn-off flag and the sync-fault pull are high and both gate enables are low.
- R7: After a soft turn-off ends with the clear input low, the shutdown pull stays high until the clear input is sampled high.
- R8: The shutdown pull is high while undervoltage is sampled high, and it drops once undervoltage is gone. Undervoltage is not latched.
- R9: While the shutdown line reads low, both gate enables are low. This is not latched: the gates follow PWM again once the line reads high, and the clear input has no effect on this condition.
- R10: While the sync-fault line reads low and no soft turn-off is running, both gate enables keep their present values whatever the PWM inputs do.
- R11: A desaturation on a gate that is on and past blanking starts a soft turn-off even while the gates are frozen.
- R12: If the clear input is high when a soft turn-off ends, the guard returns to normal operation and raises no shutdown pull.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| pwmHiIn | input | 1 | High-side PWM command |
| pwmLoIn | input | 1 | Low-side PWM command |
| desatHiIn | input | 1 | High-side desaturation comparator flag |
| desatLoIn | input | 1 | Low-side desaturation comparator flag |
| uvIn | input | 1 | Undervoltage comparator flag |
| clrIn | input | 1 | Fault clear, active high |
| syncLineIn | input | 1 | Sampled level of the shared sync-fault net (low = fault) |
| sdLineIn | input | 1 | Sampled level of the shared shutdown net (low = shut down) |
| gateHiOut | output | 1 | High-side base gate enable |
| gateLoOut | output | 1 | Low-side base gate enable |
| boostHiOut | output | 1 | High-side boost stage enable |
| boostLoOut | output | 1 | Low-side boost stage enable |
| softOffOut | output | 1 | Soft turn-off sink enable |
| syncPullOut | output | 1 | Pull-low enable for the sync-fault net |
| sdPullOut | output | 1 | Pull-low enable for the shutdown net |

## Verification
The assertions assume that a new soft turn-off never begins in the cycle right after one ends. This holds because both gates are off throughout a soft turn-off, and a desaturation is only taken from a gate that is on. The bench builds each shared net as a wired-AND of the guard's own pull and an external pull. It holds every input steady across a clock edge and changes inputs only on falling edges. Desaturation pulses are placed either inside or well outside the blanking window, so every case the reference model predicts is reached through the synchronisers.

// File: rtl/hbGuardPkg.sv
package hbGuardPkg;

  // Bit positions inside the synchroniser vector
  localparam int IDX_PWM_HI  = 0;
  localparam int IDX_PWM_LO  = 1;
  localparam int IDX_DES_HI  = 2;
  localparam int IDX_DES_LO  = 3;
  localparam int IDX_UV      = 4;
  localparam int IDX_CLR     = 5;
  localparam int IDX_SYNC    = 6;
  localparam int IDX_SD      = 7;
  localparam int SYNC_N      = 8;
  // Shared nets idle high, so their synchroniser stages reset high
  localparam logic [SYNC_N-1:0] SYNC_RST = 8'b1100_0000;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_SOFT  = 2'd1,
    ST_LATCH = 2'd2
  } guardState_t;

  typedef struct packed {
    logic forceOff;  // drive both gates low next cycle
    logic hold;      // keep gates at their present value
    logic startSsd;  // clear the soft turn-off counter
    logic runSsd;    // advance the soft turn-off counter
  } guardStrobe_t;

endpackage

// File: rtl/hbGuardPath.sv
module hbGuardPath
  import hbGuardPkg::*;
#(
  parameter int SSD_CYCLES   = 8,
  parameter int BOOST_CYCLES = 4,
  parameter int BLANK_CYCLES = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [SYNC_N-1:0]  rawIn,
  input  guardStrobe_t       strobe,
  output logic               sClr,
  output logic               sUv,
  output logic               sSdLow,
  output logic               sSyncLow,
  output logic               desatHit,
  output logic               ssdDone,
  output logic [1:0]         gateVec,
  output logic [1:0]         boostVec
);

  localparam int MAX_ON = (BLANK_CYCLES > BOOST_CYCLES) ? BLANK_CYCLES : BOOST_CYCLES;
  localparam int CNT_W  = $clog2(MAX_ON + 1);
  localparam int SSD_W  = (SSD_CYCLES > 2) ? $clog2(SSD_CYCLES) : 1;

  logic [SYNC_N-1:0] syncA, syncB;
  logic [SSD_W-1:0]  ssdCnt;
  logic [1:0]        hitVec;
  logic              bothHigh;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= SYNC_RST;
      syncB <= SYNC_RST;
    end else begin
      syncA <= rawIn;
      syncB <= syncA;
    end
  end

  assign sClr     = syncB[IDX_CLR];
  assign sUv      = syncB[IDX_UV];
  assign sSdLow   = ~syncB[IDX_SD];
  assign sSyncLow = ~syncB[IDX_SYNC];
  assign bothHigh = syncB[IDX_PWM_HI] & syncB[IDX_PWM_LO];

  // One gate channel per side: index 0 is the high side, 1 the low side
  for (genvar s = 0; s < 2; s++) begin : g_side
    logic             gate;
    logic             gateNext;
    logic [CNT_W-1:0] onCnt;
    logic             pwmOk;

    assign pwmOk = syncB[IDX_PWM_HI + s] & ~bothHigh;

    always_comb begin
      if (strobe.forceOff)  gateNext = 1'b0;
      else if (strobe.hold) gateNext = gate;
      else                  gateNext = pwmOk;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        gate  <= 1'b0;
        onCnt <= '0;
      end else begin
        gate <= gateNext;
        if (gateNext && gate) begin
          if (onCnt != CNT_W'(MAX_ON)) onCnt <= onCnt + 1'b1;
        end else begin
          onCnt <= '0;
        end
      end
    end

    assign gateVec[s]  = gate;
    assign boostVec[s] = gate && (onCnt < CNT_W'(BOOST_CYCLES));
    assign hitVec[s]   = gate && syncB[IDX_DES_HI + s] && (onCnt >= CNT_W'(BLANK_CYCLES));
  end

  assign desatHit = |hitVec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               ssdCnt <= '0;
    else if (strobe.startSsd) ssdCnt <= '0;
    else if (strobe.runSsd)   ssdCnt <= ssdCnt + 1'b1;
  end

  assign ssdDone = strobe.runSsd && (ssdCnt == SSD_W'(SSD_CYCLES - 1));

endmodule

// File: rtl/hbGuardCtrl.sv
module hbGuardCtrl
  import hbGuardPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         sClr,
  input  logic         sUv,
  input  logic         sSdLow,
  input  logic         sSyncLow,
  input  logic         desatHit,
  input  logic         ssdDone,
  output guardStrobe_t strobe,
  output logic         softOff,
  output logic         syncPull,
  output logic         sdPull
);

  guardState_t state, stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_RUN:   if (desatHit) stateNext = ST_SOFT;
      ST_SOFT:  if (ssdDone)  stateNext = sClr ? ST_RUN : ST_LATCH;
      ST_LATCH: if (sClr)     stateNext = ST_RUN;
      default:  stateNext = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_RUN;
    else       state <= stateNext;
  end

  // Desaturation outranks the freeze; shutdown line outranks the freeze too
  always_comb begin
    strobe.startSsd = desatHit && (state == ST_RUN);
    strobe.runSsd   = (state == ST_SOFT);
    strobe.forceOff = desatHit || (state != ST_RUN) || sSdLow;
    strobe.hold     = sSyncLow;
  end

  assign softOff  = (state == ST_SOFT);
  assign syncPull = (state == ST_SOFT);
  assign sdPull   = (state == ST_LATCH) || sUv;

endmodule

// File: rtl/hbGateGuard.sv
module hbGateGuard
  import hbGuardPkg::*;
#(
  parameter int SSD_CYCLES   = 8,
  parameter int BOOST_CYCLES = 4,
  parameter int BLANK_CYCLES = 6
) (
  input  logic clk,
  input  logic rstN,
  input  logic pwmHiIn,
  input  logic pwmLoIn,
  input  logic desatHiIn,
  input  logic desatLoIn,
  input  logic uvIn,
  input  logic clrIn,
  input  logic syncLineIn,
  input  logic sdLineIn,
  output logic gateHiOut,
  output logic gateLoOut,
  output logic boostHiOut,
  output logic boostLoOut,
  output logic softOffOut,
  output logic syncPullOut,
  output logic sdPullOut
);

  guardStrobe_t      strobe;
  logic              sClr, sUv, sSdLow, sSyncLow, desatHit, ssdDone;
  logic [1:0]        gateVec, boostVec;
  logic [SYNC_N-1:0] rawIn;

  assign rawIn = {sdLineIn, syncLineIn, clrIn, uvIn, desatLoIn, desatHiIn, pwmLoIn, pwmHiIn};

  hbGuardPath #(
    .SSD_CYCLES  (SSD_CYCLES),
    .BOOST_CYCLES(BOOST_CYCLES),
    .BLANK_CYCLES(BLANK_CYCLES)
  ) u_path (
    .clk      (clk),
    .rstN     (rstN),
    .rawIn    (rawIn),
    .strobe   (strobe),
    .sClr     (sClr),
    .sUv      (sUv),
    .sSdLow   (sSdLow),
    .sSyncLow (sSyncLow),
    .desatHit (desatHit),
    .ssdDone  (ssdDone),
    .gateVec  (gateVec),
    .boostVec (boostVec)
  );

  hbGuardCtrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .sClr     (sClr),
    .sUv      (sUv),
    .sSdLow   (sSdLow),
    .sSyncLow (sSyncLow),
    .desatHit (desatHit),
    .ssdDone  (ssdDone),
    .strobe   (strobe),
    .softOff  (softOffOut),
    .syncPull (syncPullOut),
    .sdPull   (sdPullOut)
  );

  assign gateHiOut  = gateVec[0];
  assign gateLoOut  = gateVec[1];
  assign boostHiOut = boostVec[0];
  assign boostLoOut = boostVec[1];

endmodule

// File: rtl/hbGateGuardChk.sv
module hbGateGuardChk #(
  parameter int SSD_CYCLES = 8
) (
  input logic clk,
  input logic rstN,
  input logic gateHiOut,
  input logic gateLoOut,
  input logic boostHiOut,
  input logic boostLoOut,
  input logic softOffOut
);

  int softLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           softLen <= 0;
    else if (softOffOut) softLen <= softLen + 1;
    else                 softLen <= 0;
  end

  a_r3_no_overlap: assert property (@(posedge clk) disable iff (!rstN)
    !(gateHiOut && gateLoOut));

  a_r4_boost_hi_in_gate: assert property (@(posedge clk) disable iff (!rstN)
    boostHiOut |-> gateHiOut);

  a_r4_boost_lo_in_gate: assert property (@(posedge clk) disable iff (!rstN)
    boostLoOut |-> gateLoOut);

  a_r4_boost_on_turn_on: assert property (@(posedge clk) disable iff (!rstN)
    $rose(gateHiOut) |-> boostHiOut);

  a_r6_gates_off_in_soft: assert property (@(posedge clk) disable iff (!rstN)
    softOffOut |-> (!gateHiOut && !gateLoOut));

  a_r6_soft_from_on_gate: assert property (@(posedge clk) disable iff (!rstN)
    $rose(softOffOut) |-> $past(gateHiOut || gateLoOut));

  a_r6_soft_not_too_long: assert property (@(posedge clk) disable iff (!rstN)
    softOffOut |-> (softLen < SSD_CYCLES));

  a_r6_soft_ends_on_time: assert property (@(posedge clk) disable iff (!rstN)
    (softOffOut && softLen == SSD_CYCLES - 1) |=> !softOffOut);

endmodule

bind hbGateGuard hbGateGuardChk #(.SSD_CYCLES(SSD_CYCLES)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .gateHiOut  (gateHiOut),
  .gateLoOut  (gateLoOut),
  .boostHiOut (boostHiOut),
  .boostLoOut (boostLoOut),
  .softOffOut (softOffOut)
);

// File: tb/test_hbGateGuard.sv
module test_hbGateGuard;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int SSD   = 8;
  localparam int BOOST = 4;
  localparam int BLANK = 6;
  localparam int MAXC  = (BLANK > BOOST) ? BLANK : BOOST;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pwmHi = 0, pwmLo = 0, desHi = 0, desLo = 0, uv = 0, clr = 0;
  logic extSd = 0, extSync = 0;
  logic gateHiOut, gateLoOut, boostHiOut, boostLoOut, softOffOut, syncPullOut, sdPullOut;
  logic sdLine, syncLine;

  int errors = 0;
  int checks = 0;
  string curReq = "R2";

  // Wired-AND of the shared nets
  assign sdLine   = !(sdPullOut || extSd);
  assign syncLine = !(syncPullOut || extSync);

  always #2.5 clk = ~clk;

  hbGateGuard #(.SSD_CYCLES(SSD), .BOOST_CYCLES(BOOST), .BLANK_CYCLES(BLANK)) i_hbGateGuard (
    .clk(clk), .rstN(rstN),
    .pwmHiIn(pwmHi), .pwmLoIn(pwmLo), .desatHiIn(desHi), .desatLoIn(desLo),
    .uvIn(uv), .clrIn(clr), .syncLineIn(syncLine), .sdLineIn(sdLine),
    .gateHiOut(gateHiOut), .gateLoOut(gateLoOut),
    .boostHiOut(boostHiOut), .boostLoOut(boostLoOut),
    .softOffOut(softOffOut), .syncPullOut(syncPullOut), .sdPullOut(sdPullOut)
  );

  // Reference model: 0 normal, 1 soft turn-off, 2 latched shutdown
  logic [7:0] m1, m2;
  int mState, mSsd;
  logic [1:0] mGate;
  int mCnt[2];

  function automatic logic mSdPull();
    return (mState == 2) || m2[4];
  endfunction

  function automatic logic mSyncPull();
    return (mState == 1);
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      m1 = 8'hC0; m2 = 8'hC0; mState = 0; mSsd = 0; mGate = 2'b00;
      mCnt[0] = 0; mCnt[1] = 0;
    end else begin
      logic [7:0] raw;
      logic hit, ng;
      logic [1:0] nGate;
      int nState, nSsd;
      int nCnt[2];
      raw = {!(mSdPull() || extSd), !(mSyncPull() || extSync), clr, uv, desLo, desHi, pwmLo, pwmHi};
      hit = 1'b0;
      for (int s = 0; s < 2; s++)
        if (mGate[s] && m2[2+s] && mCnt[s] >= BLANK) hit = 1'b1;
      nState = mState; nSsd = mSsd;
      if (mState == 0) begin
        if (hit) begin nState = 1; nSsd = 0; end
      end else if (mState == 1) begin
        if (mSsd == SSD - 1) nState = m2[5] ? 0 : 2;
        else nSsd = mSsd + 1;
      end else if (m2[5]) nState = 0;
      for (int s = 0; s < 2; s++) begin
        if (hit || mState != 0 || !m2[7]) ng = 1'b0;
        else if (!m2[6]) ng = mGate[s];
        else ng = m2[s] && !(m2[0] && m2[1]);
        nGate[s] = ng;
        if (ng && mGate[s]) nCnt[s] = (mCnt[s] < MAXC) ? mCnt[s] + 1 : MAXC;
        else nCnt[s] = 0;
      end
      mState = nState; mSsd = nSsd; mGate = nGate;
      mCnt[0] = nCnt[0]; mCnt[1] = nCnt[1];
      m2 = m1; m1 = raw;
    end
  end

  task automatic check(string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0b expected=%0b at %0t", curReq, what, act, exp, $time);
    end
  endtask

  // Compare every output against the model on each falling edge
  always @(negedge clk) begin
    if (rstN) begin
      check("gateHi",   gateHiOut,   mGate[0]);
      check("gateLo",   gateLoOut,   mGate[1]);
      check("boostHi",  boostHiOut,  mGate[0] && mCnt[0] < BOOST);
      check("boostLo",  boostLoOut,  mGate[1] && mCnt[1] < BOOST);
      check("softOff",  softOffOut,  mState == 1);
      check("syncPull", syncPullOut, mSyncPull());
      check("sdPull",   sdPullOut,   mSdPull());
    end
  end

  task automatic waitN(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clearPulse();
    clr = 1; waitN(3); clr = 0; waitN(6);
  endtask

  initial begin
    // R1: reset state
    waitN(3);
    curReq = "R1";
    check("reset gateHi",   gateHiOut,   1'b0);
    check("reset gateLo",   gateLoOut,   1'b0);
    check("reset boostHi",  boostHiOut,  1'b0);
    check("reset boostLo",  boostLoOut,  1'b0);
    check("reset softOff",  softOffOut,  1'b0);
    check("reset syncPull", syncPullOut, 1'b0);
    check("reset sdPull",   sdPullOut,   1'b0);
    rstN = 1'b1;
    waitN(4);

    // R2, R4: gates follow PWM through the synchroniser, boost after each rise
    curReq = "R2";
    pwmHi = 1; waitN(2);
    check("R2 gateHi still low before third edge", gateHiOut, 1'b0);
    waitN(1);
    check("R2 gateHi high on third edge", gateHiOut, 1'b1);
    curReq = "R4";
    waitN(9);
    pwmHi = 0; waitN(3);
    pwmLo = 1; waitN(3);
    check("R4 boostLo on first low-side cycle", boostLoOut, 1'b1);
    waitN(9);
    pwmLo = 0; waitN(4);

    // R3: both commands high gives both gates off
    curReq = "R3";
    pwmHi = 1; waitN(6);
    pwmLo = 1; waitN(5);
    check("R3 gateHi off with both commands", gateHiOut, 1'b0);
    pwmHi = 0; waitN(6);
    pwmLo = 0; waitN(4);

    // R5: desaturation during blanking is ignored
    curReq = "R5";
    pwmHi = 1; desHi = 1; waitN(5);
    desHi = 0; waitN(8);
    check("R5 no soft turn-off during blanking", softOffOut, 1'b0);
    // R5: desaturation on a gate that is off is ignored
    desLo = 1; waitN(6); desLo = 0; waitN(4);
    check("R5 desat on off gate ignored", softOffOut, 1'b0);

    // R6, R7: desaturation after blanking, soft turn-off, then latch
    curReq = "R6";
    desHi = 1; waitN(4);
    check("R6 soft turn-off running", softOffOut, 1'b1);
    desHi = 0; pwmHi = 0;
    waitN(SSD + 4);
    curReq = "R7";
    check("R7 shutdown pull latched", sdPullOut, 1'b1);
    pwmLo = 1; waitN(10);
    check("R7 gates stay off while latched", gateLoOut, 1'b0);
    clearPulse();
    check("R7 latch released by clear", sdPullOut, 1'b0);
    waitN(4);
    pwmLo = 0; waitN(4);

    // R8: undervoltage pulls the shutdown net only while present
    curReq = "R8";
    pwmHi = 1; waitN(6);
    uv = 1; waitN(6);
    check("R8 pull during undervoltage", sdPullOut, 1'b1);
    uv = 0; waitN(8);
    check("R8 pull released", sdPullOut, 1'b0);
    check("R8 gate back on", gateHiOut, 1'b1);

    // R9: external shutdown, clear has no effect, not latched
    curReq = "R9";
    extSd = 1; waitN(4);
    clr = 1; waitN(3); clr = 0; waitN(4);
    check("R9 gate off under external shutdown", gateHiOut, 1'b0);
    extSd = 0; waitN(4);
    check("R9 resumes after line high", gateHiOut, 1'b1);
    pwmHi = 0; waitN(4);

    // R10: freeze holds gates against PWM changes
    curReq = "R10";
    pwmLo = 1; waitN(8);
    extSync = 1; waitN(3);
    pwmLo = 0; pwmHi = 1; waitN(6);
    check("R10 low gate frozen on", gateLoOut, 1'b1);
    check("R10 high gate frozen off", gateHiOut, 1'b0);

    // R11: desaturation still wins while frozen
    curReq = "R11";
    desLo = 1; waitN(4);
    check("R11 soft turn-off from freeze", softOffOut, 1'b1);
    desLo = 0; waitN(SSD + 2);
    extSync = 0; pwmHi = 0; waitN(4);
    clearPulse();

    // R12: clear held during the soft turn-off prevents the latch
    curReq = "R12";
    clr = 1;
    pwmHi = 1; waitN(12);
    desHi = 1; waitN(4); desHi = 0; pwmHi = 0;
    waitN(SSD + 6);
    check("R12 no shutdown pull with clear held", sdPullOut, 1'b0);
    clr = 0; waitN(4);
    pwmLo = 1; waitN(6);
    check("R12 normal operation resumes", gateLoOut, 1'b1);
    pwmLo = 0; waitN(4);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule